// File: doc/BRIEF.md
# Three-Class Interrupt Entry Controller

This block sits next to a simple in-order pipeline and handles the hardware side of taking an interrupt. Every interrupt number has a request line, a two-bit class tag and a syndrome byte. A request can be taken only if the enable bit of its class is set in the machine state. The controller picks one winner per cycle. It saves the resume address and the current machine state into the save pair owned by the winner's class. It loads the syndrome register, moves the machine state into supervisor mode with the relevant enables masked, and gives the pipeline a one-cycle redirect to the handler address.

The handler address takes its upper half from a shared prefix register and its lower half from one of the per-interrupt offset registers, with the low four bits cleared. For each class a return request restores the machine state from that class's save pair and redirects fetch to the saved address. Software loads the machine state, the prefix and the offsets through simple write ports.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After a synchronous reset the state is 0x01 (supervisor bit 0 set; enable bits clear). Redirect, syndrome and all six save registers read zero.
- R2: The state bits are: bit 1 enables non-critical, bit 2 enables critical, bit 3 enables debug. A request whose class bit is clear is not taken: there is no redirect and the state is unchanged.
- R3: Class codes are 0 non-critical, 1 critical, 2 or 3 debug. When several classes are eligible in one cycle, debug beats critical and critical beats non-critical.
- R4: Among eligible requests of the winning class, the lowest interrupt number is taken.
- R5: On a take, the winning class's pair captures the resume address and the state as it was before entry. The other pairs keep their values. In `save_pc_o` and `save_st_o`, class c sits at slice c (0 non-critical, 1 critical, 2 debug).
- R6: On a take, state bit 0 is set. The enable bit of the taken class and the enable bits of all lower classes are cleared. All other state bits are kept.
- R7: On a take, the syndrome register loads the winner's syndrome byte.
- R8: In the cycle after a take, `redirect_o` is high for one cycle. `redirect_pc_o` is then the upper 16 prefix bits joined to the winner's 16-bit offset, with bits 3:0 zero.
- R9: A critical request preempts a running non-critical handler. A non-critical request does not preempt a critical handler, and the same class cannot re-enter.
- R10: When `dbg_unit_en_i` is low, debug-coded requests behave as critical: they are gated by bit 2, ranked as critical and saved in the critical pair.
- R11: `rfi_i[c]` restores the state from pair c and redirects to the saved address in the next cycle. If a take falls in the same cycle, the take wins.
- R12: `st_we_i` loads the state in a cycle that has neither a take nor a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | NUM_IRQ | Request line per interrupt number |
| req_cls_i | input | 2*NUM_IRQ | Class code per line |
| req_syn_i | input | SYN_W*NUM_IRQ | Syndrome byte per line |
| dbg_unit_en_i | input | 1 | Debug unit enabled |
| resume_pc_i | input | ADDR_W | Address to resume at |
| rfi_i | input | 3 | Return request per class |
| st_we_i | input | 1 | Machine state write |
| st_wdata_i | input | 8 | Machine state write data |
| pfx_we_i | input | 1 | Prefix write |
| pfx_wdata_i | input | ADDR_W/2 | Prefix write data |
| ofs_we_i | input | 1 | Offset write |
| ofs_idx_i | input | $clog2(NUM_IRQ) | Offset register number |
| ofs_wdata_i | input | ADDR_W/2 | Offset write data |
| state_o | output | 8 | Machine state |
| syndrome_o | output | SYN_W | Syndrome register |
| redirect_o | output | 1 | One-cycle fetch redirect |
| redirect_pc_o | output | ADDR_W | Redirect target |
| save_pc_o | output | 3*ADDR_W | Saved resume addresses per class |
| save_st_o | output | 24 | Saved states per class |

## Verification
A wrong enable mask shows up at `state_o` in the cycle right after entry. Within a few cycles it also shows up as a missing or unexpected redirect when a later request arrives. A wrong arbitration choice or offset lookup shows up as a mismatching `redirect_pc_o` in the cycle after the take, and a wrong choice also shows up as a wrong syndrome. A misrouted save write shows up at once in the save ports. It is seen again later as a wrong state or target when the matching return is made.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int ST_W   = 8;
    localparam int ST_SUP = 0;
    localparam int ST_EE  = 1;
    localparam int ST_CE  = 2;
    localparam int ST_DE  = 3;
    localparam int NUM_CLS = 3;

    typedef enum logic [1:0] {
        CLS_NC = 2'd0,
        CLS_CR = 2'd1,
        CLS_DB = 2'd2
    } irq_cls_e;

    typedef struct packed {
        logic     valid;
        irq_cls_e cls;
    } grant_t;

    // Map a raw class code onto the class actually used.
    function automatic irq_cls_e eff_cls(input logic [1:0] raw, input logic dbg_on);
        if (raw[1]) return dbg_on ? CLS_DB : CLS_CR;
        return raw[0] ? CLS_CR : CLS_NC;
    endfunction

    function automatic logic cls_enabled(input logic [ST_W-1:0] st, input irq_cls_e c);
        case (c)
            CLS_DB:  return st[ST_DE];
            CLS_CR:  return st[ST_CE];
            default: return st[ST_EE];
        endcase
    endfunction

    // State after entry: supervisor, taken class and lower classes masked.
    function automatic logic [ST_W-1:0] entry_state(input logic [ST_W-1:0] st, input irq_cls_e c);
        logic [ST_W-1:0] r;
        r = st;
        r[ST_SUP] = 1'b1;
        r[ST_EE]  = 1'b0;
        if (c != CLS_NC) r[ST_CE] = 1'b0;
        if (c == CLS_DB) r[ST_DE] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_entry_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    localparam int IDX_W = $clog2(NUM_IRQ)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_IRQ-1:0]   req,
    input  logic [2*NUM_IRQ-1:0] cls_raw,
    input  logic                 dbg_on,
    input  logic [ST_W-1:0]      state,
    output grant_t               grant,
    output logic [IDX_W-1:0]     grant_idx
);

    logic [NUM_IRQ-1:0] elig;
    irq_cls_e           ec [NUM_IRQ];

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        assign ec[i]   = eff_cls(cls_raw[2*i +: 2], dbg_on);
        assign elig[i] = req[i] && cls_enabled(state, ec[i]);
    end

    logic [NUM_CLS-1:0] hit;
    logic [IDX_W-1:0]   cidx [NUM_CLS];

    // Descending scan: the lowest eligible number of each class is kept.
    always_comb begin
        hit = '0;
        for (int c = 0; c < NUM_CLS; c++) cidx[c] = '0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (elig[i]) begin
                hit[int'(ec[i])]  = 1'b1;
                cidx[int'(ec[i])] = IDX_W'(i);
            end
        end
    end

    always_comb begin
        grant     = '{valid: 1'b0, cls: CLS_NC};
        grant_idx = '0;
        if (hit[CLS_DB]) begin
            grant     = '{valid: 1'b1, cls: CLS_DB};
            grant_idx = cidx[CLS_DB];
        end else if (hit[CLS_CR]) begin
            grant     = '{valid: 1'b1, cls: CLS_CR};
            grant_idx = cidx[CLS_CR];
        end else if (hit[CLS_NC]) begin
            grant     = '{valid: 1'b1, cls: CLS_NC};
            grant_idx = cidx[CLS_NC];
        end
    end

    AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        grant.valid |-> elig[grant_idx]); // R2
    AST_NC_ONLY_WHEN_ALONE: assert property (@(posedge clk) disable iff (rst)
        (grant.valid && grant.cls == CLS_NC) |-> (hit[CLS_CR] == 1'b0 && hit[CLS_DB] == 1'b0)); // R3

endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
    parameter int NUM_VEC = 16,
    parameter int ADDR_W  = 32,
    parameter int ALIGN   = 4,
    localparam int IDX_W  = $clog2(NUM_VEC),
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pfx_we,
    input  logic [HALF_W-1:0] pfx_wdata,
    input  logic              ofs_we,
    input  logic [IDX_W-1:0]  ofs_idx,
    input  logic [HALF_W-1:0] ofs_wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] handler_addr
);

    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'((64'd1 << ALIGN) - 64'd1);

    logic [HALF_W-1:0] pfx_q;
    logic [HALF_W-1:0] ofs_q [NUM_VEC];

    always_ff @(posedge clk) begin
        if (rst)         pfx_q <= '0;
        else if (pfx_we) pfx_q <= pfx_wdata;
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_ofs
        always_ff @(posedge clk) begin
            if (rst)                                   ofs_q[v] <= '0;
            else if (ofs_we && ofs_idx == IDX_W'(v))   ofs_q[v] <= ofs_wdata;
        end
    end

    assign handler_addr = {pfx_q, ofs_q[rd_idx]} & ALIGN_MASK;

endmodule

// File: rtl/irq_save_bank.sv
module irq_save_bank
    import irq_entry_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_CLS-1:0]          wr_en,
    input  logic [ADDR_W-1:0]           wr_pc,
    input  logic [ST_W-1:0]             wr_st,
    output logic [NUM_CLS*ADDR_W-1:0]   pc_flat,
    output logic [NUM_CLS*ST_W-1:0]     st_flat
);

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_pair
        logic [ADDR_W-1:0] pc_q;
        logic [ST_W-1:0]   st_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                pc_q <= '0;
                st_q <= '0;
            end else if (wr_en[c]) begin
                pc_q <= wr_pc;
                st_q <= wr_st;
            end
        end
        assign pc_flat[c*ADDR_W +: ADDR_W] = pc_q;
        assign st_flat[c*ST_W +: ST_W]     = st_q;
    end

    AST_ONE_PAIR_WRITTEN: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_en)); // R5

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int ADDR_W  = 32,
    parameter int SYN_W   = 8,
    localparam int IDX_W  = $clog2(NUM_IRQ),
    localparam int HALF_W = ADDR_W / 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_IRQ-1:0]         req_i,
    input  logic [2*NUM_IRQ-1:0]       req_cls_i,
    input  logic [SYN_W*NUM_IRQ-1:0]   req_syn_i,
    input  logic                       dbg_unit_en_i,
    input  logic [ADDR_W-1:0]          resume_pc_i,
    input  logic [2:0]                 rfi_i,
    input  logic                       st_we_i,
    input  logic [7:0]                 st_wdata_i,
    input  logic                       pfx_we_i,
    input  logic [HALF_W-1:0]          pfx_wdata_i,
    input  logic                       ofs_we_i,
    input  logic [IDX_W-1:0]           ofs_idx_i,
    input  logic [HALF_W-1:0]          ofs_wdata_i,
    output logic [7:0]                 state_o,
    output logic [SYN_W-1:0]           syndrome_o,
    output logic                       redirect_o,
    output logic [ADDR_W-1:0]          redirect_pc_o,
    output logic [3*ADDR_W-1:0]        save_pc_o,
    output logic [23:0]                save_st_o
);

    logic [ST_W-1:0]   state_q;
    logic [SYN_W-1:0]  syn_q;
    logic              redir_q;
    logic [ADDR_W-1:0] redir_pc_q;

    grant_t            grant;
    logic [IDX_W-1:0]  grant_idx;
    logic [ADDR_W-1:0] handler_addr;
    logic              take;
    logic              ret;
    irq_cls_e          ret_cls;
    logic [NUM_CLS-1:0] save_we;
    logic [SYN_W-1:0]  sel_syn;
    logic [ADDR_W-1:0] ret_pc;
    logic [ST_W-1:0]   ret_st;

    irq_pick #(.NUM_IRQ(NUM_IRQ)) u_pick (
        .clk       (clk),
        .rst       (rst),
        .req       (req_i),
        .cls_raw   (req_cls_i),
        .dbg_on    (dbg_unit_en_i),
        .state     (state_q),
        .grant     (grant),
        .grant_idx (grant_idx)
    );

    irq_vec_table #(.NUM_VEC(NUM_IRQ), .ADDR_W(ADDR_W), .ALIGN(4)) u_vec (
        .clk          (clk),
        .rst          (rst),
        .pfx_we       (pfx_we_i),
        .pfx_wdata    (pfx_wdata_i),
        .ofs_we       (ofs_we_i),
        .ofs_idx      (ofs_idx_i),
        .ofs_wdata    (ofs_wdata_i),
        .rd_idx       (grant_idx),
        .handler_addr (handler_addr)
    );

    assign take    = grant.valid;
    assign save_we = take ? NUM_CLS'(1 << int'(grant.cls)) : '0;

    irq_save_bank #(.ADDR_W(ADDR_W)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (save_we),
        .wr_pc   (resume_pc_i),
        .wr_st   (state_q),
        .pc_flat (save_pc_o),
        .st_flat (save_st_o)
    );

    // Return decode: the highest requested class is used.
    always_comb begin
        ret     = |rfi_i;
        ret_cls = rfi_i[2] ? CLS_DB : (rfi_i[1] ? CLS_CR : CLS_NC);
    end

    assign ret_pc  = save_pc_o[int'(ret_cls)*ADDR_W +: ADDR_W];
    assign ret_st  = save_st_o[int'(ret_cls)*ST_W +: ST_W];
    assign sel_syn = req_syn_i[int'(grant_idx)*SYN_W +: SYN_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_W'(1) << ST_SUP;
            syn_q      <= '0;
            redir_q    <= 1'b0;
            redir_pc_q <= '0;
        end else if (take) begin
            state_q    <= entry_state(state_q, grant.cls);
            syn_q      <= sel_syn;
            redir_q    <= 1'b1;
            redir_pc_q <= handler_addr;
        end else if (ret) begin
            state_q    <= ret_st;
            redir_q    <= 1'b1;
            redir_pc_q <= ret_pc;
        end else begin
            redir_q    <= 1'b0;
            if (st_we_i) state_q <= st_wdata_i;
        end
    end

    assign state_o       = state_q;
    assign syndrome_o    = syn_q;
    assign redirect_o    = redir_q;
    assign redirect_pc_o = redir_pc_q;

    AST_SUP_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
        take |=> state_o[ST_SUP]); // R6
    AST_SAME_CLASS_MASKED: assert property (@(posedge clk) disable iff (rst)
        (take && grant.cls == CLS_NC) |=> !state_o[ST_EE]); // R9
    AST_DEBUG_MASKS_ALL: assert property (@(posedge clk) disable iff (rst)
        (take && grant.cls == CLS_DB) |=> (state_o[ST_EE] == 1'b0 && state_o[ST_CE] == 1'b0 && state_o[ST_DE] == 1'b0)); // R6
    AST_REDIRECT_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        take |=> redirect_o); // R8
    AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        take |=> (redirect_pc_o[3:0] == 4'h0)); // R8
    AST_SYNDROME_LOADED: assert property (@(posedge clk) disable iff (rst)
        take |=> (syndrome_o == $past(sel_syn))); // R7
    AST_CRIT_PC_SAVED: assert property (@(posedge clk) disable iff (rst)
        (take && grant.cls == CLS_CR) |=> (save_pc_o[ADDR_W +: ADDR_W] == $past(resume_pc_i))); // R5
    AST_QUIET_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (!take && !ret) |=> !redirect_o); // R2
    AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (!take && ret) |=> (state_o == $past(ret_st))); // R11

endmodule

// File: tb/test_irq_entry_ctrl.sv
module test_irq_entry_ctrl;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [15:0]  req = '0;
    logic [31:0]  req_cls = '0;
    logic [127:0] req_syn = '0;
    logic         dbg_en = 1'b1;
    logic [31:0]  resume_pc = '0;
    logic [2:0]   rfi = '0;
    logic         st_we = 1'b0;
    logic [7:0]   st_wdata = '0;
    logic         pfx_we = 1'b0;
    logic [15:0]  pfx_wdata = '0;
    logic         ofs_we = 1'b0;
    logic [3:0]   ofs_idx = '0;
    logic [15:0]  ofs_wdata = '0;
    logic [7:0]   state;
    logic [7:0]   syndrome;
    logic         redirect;
    logic [31:0]  redirect_pc;
    logic [95:0]  save_pc;
    logic [23:0]  save_st;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q [$];
    logic [15:0] ofs_model [16];

    always #5 clk = ~clk;

    irq_entry_ctrl i_irq_entry_ctrl (
        .clk(clk), .rst(rst), .req_i(req), .req_cls_i(req_cls), .req_syn_i(req_syn),
        .dbg_unit_en_i(dbg_en), .resume_pc_i(resume_pc), .rfi_i(rfi),
        .st_we_i(st_we), .st_wdata_i(st_wdata), .pfx_we_i(pfx_we), .pfx_wdata_i(pfx_wdata),
        .ofs_we_i(ofs_we), .ofs_idx_i(ofs_idx), .ofs_wdata_i(ofs_wdata),
        .state_o(state), .syndrome_o(syndrome), .redirect_o(redirect),
        .redirect_pc_o(redirect_pc), .save_pc_o(save_pc), .save_st_o(save_st)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] vec(input int n);
        return {16'hABCD, ofs_model[n] & 16'hFFF0};
    endfunction

    // Scoreboard monitor: every redirect must match the next expected target.
    always @(negedge clk) begin
        if (!rst && redirect) begin
            if (exp_q.size() == 0) chk(1'b0, "R8 unexpected redirect", redirect_pc, 32'h0);
            else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(redirect_pc == e, "R8/R11 redirect target", redirect_pc, e);
            end
        end
    end

    task automatic pulse();
        @(posedge clk);
        #1;
        req = '0; rfi = '0; st_we = 1'b0; pfx_we = 1'b0; ofs_we = 1'b0;
    endtask

    task automatic line(input int n, input logic [1:0] c);
        req[n] = 1'b1;
        req_cls[2*n +: 2] = c;
        req_syn[8*n +: 8] = 8'h40 + 8'(n);
    endtask

    task automatic set_state(input logic [7:0] v);
        st_we = 1'b1; st_wdata = v;
        pulse();
        chk(state == v, "R12 state write", {24'h0, state}, {24'h0, v});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk(state == 8'h01, "R1 reset state", {24'h0, state}, 32'h01);
        chk(redirect == 1'b0 && syndrome == 8'h0, "R1 reset redirect/syndrome", {23'h0, redirect, syndrome}, 32'h0);
        chk(save_pc == '0 && save_st == '0, "R1 reset save regs", save_pc[31:0], 32'h0);

        pfx_we = 1'b1; pfx_wdata = 16'hABCD;
        pulse();
        for (int i = 0; i < 16; i++) begin
            ofs_model[i] = 16'h1000 + 16'(i) * 16'h0111;
            ofs_we = 1'b1; ofs_idx = 4'(i); ofs_wdata = ofs_model[i];
            pulse();
        end

        // R2: class disabled in reset state
        line(3, 2'd0); resume_pc = 32'h0000_0100;
        pulse();
        chk(redirect == 1'b0, "R2 masked request no redirect", {31'h0, redirect}, 32'h0);
        chk(state == 8'h01, "R2 masked request state kept", {24'h0, state}, 32'h01);

        set_state(8'hAF);

        // R4/R5/R6/R7/R8: two non-critical lines, lowest wins
        line(5, 2'd0); line(2, 2'd0); resume_pc = 32'h1000_0040;
        exp_q.push_back(vec(2));
        pulse();
        chk(state == 8'hAD, "R6 entry state non-critical", {24'h0, state}, 32'hAD);
        chk(syndrome == 8'h42, "R4/R7 syndrome of lowest line", {24'h0, syndrome}, 32'h42);
        chk(save_pc[31:0] == 32'h1000_0040, "R5 non-critical saved pc", save_pc[31:0], 32'h1000_0040);
        chk(save_st[7:0] == 8'hAF, "R5 non-critical saved state", {24'h0, save_st[7:0]}, 32'hAF);
        chk(save_pc[95:32] == '0, "R5 other pairs untouched", save_pc[63:32], 32'h0);

        // R9: same class blocked
        line(1, 2'd0);
        pulse();
        chk(redirect == 1'b0 && state == 8'hAD, "R9 no same-class re-entry", {24'h0, state}, 32'hAD);

        // R9: critical preempts non-critical handler
        line(7, 2'd1); resume_pc = 32'h2000_0080;
        exp_q.push_back(vec(7));
        pulse();
        chk(state == 8'hA9, "R9 critical preempts", {24'h0, state}, 32'hA9);
        chk(save_pc[63:32] == 32'h2000_0080 && save_st[15:8] == 8'hAD, "R5 critical pair", save_pc[63:32], 32'h2000_0080);

        line(1, 2'd0);
        pulse();
        chk(redirect == 1'b0 && state == 8'hA9, "R9 non-critical blocked in critical", {24'h0, state}, 32'hA9);

        // R3: all three classes together
        set_state(8'hAF);
        line(4, 2'd0); line(9, 2'd1); line(12, 2'd2); resume_pc = 32'h3000_00C0;
        exp_q.push_back(vec(12));
        pulse();
        chk(state == 8'hA1, "R3 debug wins / R6 all masked", {24'h0, state}, 32'hA1);
        chk(syndrome == 8'h4C, "R3 debug syndrome", {24'h0, syndrome}, 32'h4C);
        chk(save_pc[95:64] == 32'h3000_00C0 && save_st[23:16] == 8'hAF, "R5 debug pair", save_pc[95:64], 32'h3000_00C0);

        // R11: debug return
        rfi = 3'b100;
        exp_q.push_back(32'h3000_00C0);
        pulse();
        chk(state == 8'hAF, "R11 return restores state", {24'h0, state}, 32'hAF);

        // R10: debug unit disabled -> treated as critical
        dbg_en = 1'b0;
        line(12, 2'd3); resume_pc = 32'h4000_0010;
        exp_q.push_back(vec(12));
        pulse();
        chk(state == 8'hA9, "R10 debug-as-critical entry state", {24'h0, state}, 32'hA9);
        chk(save_pc[63:32] == 32'h4000_0010, "R10 saved in critical pair", save_pc[63:32], 32'h4000_0010);
        chk(save_pc[95:64] == 32'h3000_00C0, "R10 debug pair untouched", save_pc[95:64], 32'h3000_00C0);
        rfi = 3'b010;
        exp_q.push_back(32'h4000_0010);
        pulse();
        chk(state == 8'hAF, "R11 critical return", {24'h0, state}, 32'hAF);

        set_state(8'hAB);
        line(12, 2'd2);
        pulse();
        chk(redirect == 1'b0 && state == 8'hAB, "R10 gated by critical enable", {24'h0, state}, 32'hAB);
        dbg_en = 1'b1;
        line(12, 2'd2); resume_pc = 32'h5000_0020;
        exp_q.push_back(vec(12));
        pulse();
        chk(state == 8'hA1, "R10 debug unit on uses debug class", {24'h0, state}, 32'hA1);

        // R11: take wins over return in the same cycle
        set_state(8'hAF);
        line(6, 2'd0); rfi = 3'b001; resume_pc = 32'h6000_0030;
        exp_q.push_back(vec(6));
        pulse();
        chk(state == 8'hAD, "R11 take beats return", {24'h0, state}, 32'hAD);
        chk(save_pc[31:0] == 32'h6000_0030, "R11 take saved pc", save_pc[31:0], 32'h6000_0030);

        @(posedge clk); #1;
        chk(exp_q.size() == 0, "R8 all redirects seen", exp_q.size(), 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule